// File: doc/BRIEF.md
# Programmable Microcycle Delay Timer

This block waits for a programmable number of microcycles. A start pulse captures two unsigned bytes: an accumulator count and a displacement count. The block then stays busy for exactly `13 + 2*acc + 514*disp` ticks of a microcycle enable and marks the end with a one-cycle done pulse. The shortest wait is 13 ticks (both bytes zero). The longest is 131593 ticks (both bytes 255). Time advances only on clock cycles where the tick enable is high, so the same block serves at any ratio between the clock and the microcycle rate.

A separate combinational fitter solves the reverse problem. Given a requested tick count, it returns the byte pair that comes closest without going over. It takes the displacement as the whole number of 514-tick blocks above the fixed 13. It takes the accumulator as half of what is left, rounded down. Inside the reachable range the resulting wait is exact or one tick short. The one exception is a remainder of 512 or 513 ticks: half of it does not fit in a byte, so the accumulator is capped at 255. Requests that are too small or too large saturate.

Top module: `mcyc_delay_timer`

## Requirements
- R1: After reset, busy and done are both low and stay low until a start is accepted.
- R2: A start pulse while idle captures acc_in and disp_in. Busy is high from the next cycle. Busy falls on the clock edge of the Nth tick-enabled cycle counted after that, where N = 13 + 2*acc_in + 514*disp_in (unsigned bytes).
- R3: While busy, a cycle with tick_en low changes nothing: busy stays high and no done appears.
- R4: Done is high for exactly one cycle. That cycle is the first one in which busy reads low after a run, and done is never high while busy is high.
- R5: A start pulse while busy is ignored, whatever its byte values. The running wait keeps its original length.
- R6: The extreme settings give 13 ticks (acc 0, disp 0) and 131593 ticks (acc 255, disp 255).
- R7: For 13 <= req_len <= 131593, fit_disp = floor((req_len-13)/514). fit_acc = floor(((req_len-13) - 514*fit_disp)/2), capped at 255.
- R8: For req_len < 13 the fitter outputs 0 and 0. For req_len > 131593 it outputs 255 and 255.
- R9: For 13 <= req_len <= 131593, the wait produced by the fitted pair never exceeds req_len and falls short of it by at most 3 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Microcycle enable; the wait advances one tick per high cycle |
| start | input | 1 | Start pulse, taken only while idle |
| acc_in | input | 8 | Accumulator count, unsigned, weight 2 ticks |
| disp_in | input | 8 | Displacement count, unsigned, weight 514 ticks |
| busy | output | 1 | High while a wait is running |
| done | output | 1 | One-cycle pulse after the final tick |
| req_len | input | 18 | Requested wait in ticks for the fitter |
| fit_acc | output | 8 | Fitted accumulator count |
| fit_disp | output | 8 | Fitted displacement count |

## Verification
The timer is run with a tick enable held high, which checks the exact count at both extremes. It is also run with a random tick pattern, which shows that only enabled cycles count. A third pattern starves the tick for a stretch, which separates "stalled" from "finished".

Some runs get start pulses with new byte values mid-wait. If those pulses were taken, the measured length would change, so these runs expose a wrongly accepted start.

The fitter is tried at the following points:
- both range edges and just outside them, which separates saturation from the normal formula;
- remainders of 512 and 513, which exercise the cap;
- worked values from the delay formula;
- random requests.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int unsigned DEF_ACC_W   = 8;
  localparam int unsigned DEF_DISP_W  = 8;
  localparam int unsigned DEF_BASE    = 13;
  localparam int unsigned DEF_ACC_WT  = 2;
  localparam int unsigned DEF_DISP_WT = 514;

  function automatic int unsigned span_max(input int unsigned base,
                                           input int unsigned acc_w,
                                           input int unsigned disp_w,
                                           input int unsigned acc_wt,
                                           input int unsigned disp_wt);
    return base + acc_wt * ((1 << acc_w) - 1) + disp_wt * ((1 << disp_w) - 1);
  endfunction
endpackage

// File: rtl/mcyc_span_calc.sv
module mcyc_span_calc #(
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned DISP_W  = 8,
  parameter int unsigned BASE    = 13,
  parameter int unsigned ACC_WT  = 2,
  parameter int unsigned DISP_WT = 514,
  parameter int unsigned CNT_W   = 18
) (
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [DISP_W-1:0] disp_in,
  output logic [CNT_W-1:0]  span
);
  logic [CNT_W-1:0] acc_part;
  logic [CNT_W-1:0] disp_part;

  always_comb begin
    acc_part  = CNT_W'(ACC_WT) * CNT_W'(acc_in);
    disp_part = CNT_W'(DISP_WT) * CNT_W'(disp_in);
    span      = CNT_W'(BASE) + acc_part + disp_part;
  end
endmodule

// File: rtl/mcyc_down_counter.sv
module mcyc_down_counter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remaining,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (load) begin
        cnt_d  = load_val;
        busy_d = (load_val != '0);
      end
    end else if (tick_en) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign remaining = cnt_q;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/mcyc_fit_solver.sv
module mcyc_fit_solver #(
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned DISP_W  = 8,
  parameter int unsigned BASE    = 13,
  parameter int unsigned ACC_WT  = 2,
  parameter int unsigned DISP_WT = 514,
  parameter int unsigned CNT_W   = 18,
  parameter int unsigned MAX_LEN = 131593
) (
  input  logic [CNT_W-1:0]  req_len,
  output logic [ACC_W-1:0]  fit_acc,
  output logic [DISP_W-1:0] fit_disp
);
  localparam logic [CNT_W-1:0] ACC_TOP = CNT_W'((1 << ACC_W) - 1);

  logic [CNT_W-1:0] above;
  logic [CNT_W-1:0] blocks;
  logic [CNT_W-1:0] rest;
  logic [CNT_W-1:0] halves;

  always_comb begin
    above  = req_len - CNT_W'(BASE);
    blocks = above / CNT_W'(DISP_WT);
    rest   = above - blocks * CNT_W'(DISP_WT);
    halves = rest / CNT_W'(ACC_WT);
    if (halves > ACC_TOP) halves = ACC_TOP;
    if (req_len < CNT_W'(BASE)) begin
      fit_acc  = '0;
      fit_disp = '0;
    end else if (req_len > CNT_W'(MAX_LEN)) begin
      fit_acc  = '1;
      fit_disp = '1;
    end else begin
      fit_acc  = halves[ACC_W-1:0];
      fit_disp = blocks[DISP_W-1:0];
    end
  end
endmodule

// File: rtl/mcyc_delay_timer.sv
module mcyc_delay_timer
  import mcyc_pkg::*;
#(
  parameter int unsigned ACC_W   = DEF_ACC_W,
  parameter int unsigned DISP_W  = DEF_DISP_W,
  parameter int unsigned BASE    = DEF_BASE,
  parameter int unsigned ACC_WT  = DEF_ACC_WT,
  parameter int unsigned DISP_WT = DEF_DISP_WT,
  parameter int unsigned MAX_LEN = span_max(BASE, ACC_W, DISP_W, ACC_WT, DISP_WT),
  parameter int unsigned CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              start,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [DISP_W-1:0] disp_in,
  output logic              busy,
  output logic              done,
  input  logic [CNT_W-1:0]  req_len,
  output logic [ACC_W-1:0]  fit_acc,
  output logic [DISP_W-1:0] fit_disp
);
  logic             rst_meta_n, rst_q_n;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  mcyc_span_calc #(
    .ACC_W(ACC_W), .DISP_W(DISP_W), .BASE(BASE),
    .ACC_WT(ACC_WT), .DISP_WT(DISP_WT), .CNT_W(CNT_W)
  ) u_span (
    .acc_in (acc_in),
    .disp_in(disp_in),
    .span   (span)
  );

  mcyc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tick_en  (tick_en),
    .load     (start),
    .load_val (span),
    .remaining(remaining),
    .busy     (busy),
    .done     (done)
  );

  mcyc_fit_solver #(
    .ACC_W(ACC_W), .DISP_W(DISP_W), .BASE(BASE),
    .ACC_WT(ACC_WT), .DISP_WT(DISP_WT), .CNT_W(CNT_W), .MAX_LEN(MAX_LEN)
  ) u_fit (
    .req_len (req_len),
    .fit_acc (fit_acc),
    .fit_disp(fit_disp)
  );
endmodule

// File: rtl/mcyc_delay_chk.sv
module mcyc_delay_chk #(
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned DISP_W  = 8,
  parameter int unsigned BASE    = 13,
  parameter int unsigned ACC_WT  = 2,
  parameter int unsigned DISP_WT = 514,
  parameter int unsigned MAX_LEN = 131593,
  parameter int unsigned CNT_W   = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              start,
  input logic [ACC_W-1:0]  acc_in,
  input logic [DISP_W-1:0] disp_in,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  remaining,
  input logic [CNT_W-1:0]  req_len,
  input logic [ACC_W-1:0]  fit_acc,
  input logic [DISP_W-1:0] fit_disp
);
  int unsigned reach;
  always_comb reach = BASE + ACC_WT * int'(fit_acc) + DISP_WT * int'(fit_disp);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && int'(remaining) ==
      int'(BASE + ACC_WT * int'($past(acc_in)) + DISP_WT * int'($past(disp_in)))));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en) |=> (busy && !done && $stable(remaining)));

  // R4
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(tick_en)));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && tick_en && remaining > CNT_W'(1)) |=>
      (busy && remaining == $past(remaining) - 1'b1));

  // R9
  fit_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(req_len) >= int'(BASE) && int'(req_len) <= int'(MAX_LEN)) |->
      (reach <= int'(req_len) && int'(req_len) - reach <= 3));
endmodule

bind mcyc_delay_timer mcyc_delay_chk #(
  .ACC_W(ACC_W), .DISP_W(DISP_W), .BASE(BASE), .ACC_WT(ACC_WT),
  .DISP_WT(DISP_WT), .MAX_LEN(MAX_LEN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_q_n), .tick_en(tick_en), .start(start),
  .acc_in(acc_in), .disp_in(disp_in), .busy(busy), .done(done),
  .remaining(remaining), .req_len(req_len), .fit_acc(fit_acc),
  .fit_disp(fit_disp)
);

// File: tb/mcyc_delay_timer_tb.sv
`timescale 1ns/1ps
module mcyc_delay_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        start;
  logic [7:0]  acc_in;
  logic [7:0]  disp_in;
  logic        busy;
  logic        done;
  logic [17:0] req_len;
  logic [7:0]  fit_acc;
  logic [7:0]  fit_disp;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  mcyc_delay_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
    .acc_in(acc_in), .disp_in(disp_in), .busy(busy), .done(done),
    .req_len(req_len), .fit_acc(fit_acc), .fit_disp(fit_disp)
  );

  function automatic int exp_len(input int a, input int d);
    return 13 + 2 * a + 514 * d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: tick always, 1: random tick, 2: 40-cycle starve then tick always
  task automatic run_case(input int a, input int d, input int mode, input bit poke, input string req);
    int n = exp_len(a, d);
    int ticks = 0;
    int cyc = 0;
    bit early_done = 0;
    @(negedge clk);
    acc_in = 8'(a); disp_in = 8'(d); start = 1'b1; tick_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (mode == 2) begin
      repeat (40) @(negedge clk);
      // R3: no ticks, must still be busy with no done
      chk(busy == 1'b1 && done == 1'b0, "R3 stalled without tick", int'(busy), 1);
    end
    while (1) begin
      tick_en = (mode == 1) ? 1'($urandom % 2) : 1'b1;
      if (poke && cyc == 7) begin
        start = 1'b1; acc_in = 8'($urandom); disp_in = 8'($urandom);
      end
      @(negedge clk);
      start = 1'b0;
      if (tick_en) ticks++;
      cyc++;
      if (!busy) break;
      if (done) early_done = 1;
      if (ticks > n + 4) break;
    end
    tick_en = 1'b0;
    chk(ticks == n, req, ticks, n);
    chk(!early_done, "R4 no done while busy", int'(early_done), 0);
    chk(done == 1'b1, "R4 done at busy fall", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R4 done one cycle", int'(done), 0);
  endtask

  task automatic fit_case(input int m);
    int ea, ed, reach;
    if (m < 13) begin ea = 0; ed = 0; end
    else if (m > 131593) begin ea = 255; ed = 255; end
    else begin
      ed = (m - 13) / 514;
      ea = ((m - 13) - 514 * ed) / 2;
      if (ea > 255) ea = 255;
    end
    req_len = 18'(m);
    #1;
    if (m < 13 || m > 131593) begin
      chk(int'(fit_acc) == ea, "R8 fit acc saturate", int'(fit_acc), ea);
      chk(int'(fit_disp) == ed, "R8 fit disp saturate", int'(fit_disp), ed);
    end else begin
      chk(int'(fit_acc) == ea, "R7 fit acc", int'(fit_acc), ea);
      chk(int'(fit_disp) == ed, "R7 fit disp", int'(fit_disp), ed);
      reach = exp_len(int'(fit_acc), int'(fit_disp));
      chk(reach <= m && m - reach <= 3, "R9 fit reach", reach, m);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_en = 1'b0; start = 1'b0;
    acc_in = '0; disp_in = '0; req_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(busy == 1'b0 && done == 1'b0, "R1 reset idle", int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle holds", int'(done), 0);

    run_case(0, 0, 0, 0, "R6 minimum 13");
    run_case(25, 0, 1, 0, "R2 acc 25 random tick");
    run_case(0, 1, 1, 0, "R2 disp 1 random tick");
    run_case(3, 0, 2, 0, "R3 starved then counted");
    run_case(40, 0, 0, 1, "R5 start while busy ignored");
    run_case(200, 1, 1, 1, "R5 start ignored random tick");
    for (int i = 0; i < 6; i++) begin
      run_case(int'($urandom % 256), int'($urandom % 3), int'($urandom % 2), 0, "R2 random setting");
    end
    run_case(255, 255, 0, 0, "R6 maximum 131593");

    fit_case(0); fit_case(12); fit_case(13); fit_case(63); fit_case(527);
    fit_case(5603); fit_case(525); fit_case(526); fit_case(131593);
    fit_case(131594); fit_case(262143);
    for (int i = 0; i < 30; i++) fit_case(int'($urandom % 140000));

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule